// File: doc/BRIEF.md
# Intel HEX Record Parser and Checker

This block reads a text stream in Intel HEX form, one ASCII character per beat on a valid-qualified input. It locates the start mark of each record, turns pairs of hex digits into bytes, and splits every record into its byte count, 16-bit load offset, type and payload. The trailing checksum byte of every record is verified in hardware.

Payload bytes of data records leave the block one per cycle, in file order, each tagged with its byte offset. The offset of byte k of a record is the record's load offset plus k, taken modulo 65536, so streams larger than 64 KiB wrap cleanly. Extension records (type 04) and any other non-data type are consumed silently. An end-of-file record with a good checksum raises a sticky done flag, and the parser then ignores all further input until reset. Line breaks between records are skipped. Malformed text and bad checksums are reported as one-cycle error pulses, and the parser then waits for the next start mark.

Top module: `hex_record_parser`

## Requirements
- R1: While `rst` is high on a clock edge, the following cycle shows `out_valid`, `err_csum`, `err_format` and `done` all low.
- R2: The hex digits 0-9, A-F and a-f are accepted; each byte is the first digit as the upper nibble and the second as the lower nibble.
- R3: For a type 0x00 record, each payload byte appears on `out_byte` with `out_valid` high for one cycle, in the cycle after the beat that carried its second digit. `out_offset` equals the load offset plus the byte's index within the record, modulo 65536.
- R4: Records of type 0x04, or of any type other than 0x00, never raise `out_valid`.
- R5: A record is valid when the 8-bit sum of its count, both offset bytes, its type, its payload and its checksum byte is zero. Otherwise `err_csum` pulses for one cycle, in the cycle after the beat that carried the last checksum digit.
- R6: Between records, carriage return (0x0D) and line feed (0x0A) are skipped without effect. Any other character there, except the start mark ':' (0x3A), pulses `err_format`.
- R7: Inside a record, a character that is not a hex digit (CR, LF and ':' included) pulses `err_format` in the next cycle. The record is then abandoned, and the parser waits for a new ':'.
- R8: A type 0x01 record with a correct checksum raises `done` in the cycle after its last digit. `done` stays high until reset, and while it is high no further output or error is produced.
- R9: A type 0x01 record with a wrong checksum gives `err_csum`, leaves `done` low, and parsing continues with the next record.
- R10: A cycle with `in_valid` low has no effect, whatever `in_char` carries.
- R11: A record with a byte count of zero is checked normally and produces no data output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_char` this cycle |
| in_char | input | 8 | ASCII character of the HEX text |
| out_valid | output | 1 | Payload byte strobe |
| out_byte | output | 8 | Payload byte |
| out_offset | output | 16 | Byte offset of `out_byte` |
| err_csum | output | 1 | One-cycle pulse: record checksum mismatch |
| err_format | output | 1 | One-cycle pulse: illegal character or truncated record |
| done | output | 1 | Sticky: valid end-of-file record seen |

## Verification
The assertions assume that at most one character arrives per clock, that `in_valid` is never unknown once reset is released, and that reset is held across at least one rising edge before checking starts. With those assumptions, output strobes and error pulses can never coincide, and each one can be traced to an accepted beat in the cycle before. The stimulus changes inputs only on the falling edge and delivers exactly one character per beat. Idle beats carry a ':' on `in_char` with `in_valid` low, which shows that such data is ignored. Records are built in the bench with computed checksums, and some are deliberately corrupted or truncated to reach the error paths.

// File: rtl/hexp_pkg.sv
package hexp_pkg;
  localparam int CHAR_W = 8;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int OFF_W  = 2 * BYTE_W;

  localparam logic [CHAR_W-1:0] CH_MARK = 8'h3A;
  localparam logic [CHAR_W-1:0] CH_CR   = 8'h0D;
  localparam logic [CHAR_W-1:0] CH_LF   = 8'h0A;

  localparam logic [BYTE_W-1:0] TYPE_DATA = 8'h00;
  localparam logic [BYTE_W-1:0] TYPE_EOF  = 8'h01;

  typedef enum logic [1:0] {PS_HUNT, PS_BODY, PS_DONE} pstate_e;
  typedef enum logic [2:0] {FLD_LEN, FLD_OFH, FLD_OFL, FLD_TYP, FLD_DAT, FLD_SUM} field_e;
endpackage

// File: rtl/hexp_char_class.sv
module hexp_char_class
  import hexp_pkg::*;
(
  input  logic [CHAR_W-1:0] ch,
  output logic              is_hex,
  output logic [NIB_W-1:0]  nib,
  output logic              is_mark,
  output logic              is_eol
);
  always_comb begin
    is_hex = 1'b1;
    nib    = '0;
    if (ch >= 8'h30 && ch <= 8'h39) begin
      nib = ch[NIB_W-1:0];
    end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
      nib = ch[NIB_W-1:0] + NIB_W'(9);
    end else begin
      is_hex = 1'b0;
    end
  end

  assign is_mark = (ch == CH_MARK);
  assign is_eol  = (ch == CH_CR) || (ch == CH_LF);
endmodule

// File: rtl/hexp_nibble_pair.sv
module hexp_nibble_pair
  import hexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              nib_valid,
  input  logic [NIB_W-1:0]  nib,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_val
);
  logic             phase;
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase <= 1'b0;
      hi_q  <= '0;
    end else if (nib_valid) begin
      phase <= ~phase;
      if (!phase) hi_q <= nib;
    end
  end

  assign byte_valid = nib_valid && phase;
  assign byte_val   = {hi_q, nib};
endmodule

// File: rtl/hexp_record_fsm.sv
module hexp_record_fsm
  import hexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              is_hex,
  input  logic              is_mark,
  input  logic              is_eol,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              in_body,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [OFF_W-1:0]  out_offset,
  output logic              err_csum,
  output logic              err_format,
  output logic              done
);
  pstate_e           pstate;
  field_e            field;
  logic [BYTE_W-1:0] remain;
  logic [BYTE_W-1:0] rtype;
  logic [BYTE_W-1:0] sum_q;
  logic [OFF_W-1:0]  off_q;
  logic [BYTE_W-1:0] sum_n;

  assign sum_n   = sum_q + byte_val;
  assign in_body = (pstate == PS_BODY);

  always_ff @(posedge clk) begin
    if (rst) begin
      pstate     <= PS_HUNT;
      field      <= FLD_LEN;
      remain     <= '0;
      rtype      <= '0;
      sum_q      <= '0;
      off_q      <= '0;
      out_valid  <= 1'b0;
      out_byte   <= '0;
      out_offset <= '0;
      err_csum   <= 1'b0;
      err_format <= 1'b0;
      done       <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      err_csum   <= 1'b0;
      err_format <= 1'b0;
      unique case (pstate)
        PS_HUNT: begin
          if (in_valid) begin
            if (is_mark) begin
              pstate <= PS_BODY;
              field  <= FLD_LEN;
              sum_q  <= '0;
            end else if (!is_eol) begin
              err_format <= 1'b1;
            end
          end
        end
        PS_BODY: begin
          if (in_valid && !is_hex) begin
            err_format <= 1'b1;
            pstate     <= PS_HUNT;
          end else if (byte_valid) begin
            sum_q <= sum_n;
            unique case (field)
              FLD_LEN: begin
                remain <= byte_val;
                field  <= FLD_OFH;
              end
              FLD_OFH: begin
                off_q[OFF_W-1:BYTE_W] <= byte_val;
                field <= FLD_OFL;
              end
              FLD_OFL: begin
                off_q[BYTE_W-1:0] <= byte_val;
                field <= FLD_TYP;
              end
              FLD_TYP: begin
                rtype <= byte_val;
                field <= (remain == '0) ? FLD_SUM : FLD_DAT;
              end
              FLD_DAT: begin
                if (rtype == TYPE_DATA) begin
                  out_valid  <= 1'b1;
                  out_byte   <= byte_val;
                  out_offset <= off_q;
                end
                off_q  <= off_q + OFF_W'(1);
                remain <= remain - BYTE_W'(1);
                if (remain == BYTE_W'(1)) field <= FLD_SUM;
              end
              FLD_SUM: begin
                pstate <= PS_HUNT;
                if (sum_n != '0) begin
                  err_csum <= 1'b1;
                end else if (rtype == TYPE_EOF) begin
                  pstate <= PS_DONE;
                  done   <= 1'b1;
                end
              end
              default: field <= FLD_LEN;
            endcase
          end
        end
        PS_DONE: begin
          done <= 1'b1;
        end
        default: pstate <= PS_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/hex_record_parser.sv
module hex_record_parser
  import hexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_char,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [OFF_W-1:0]  out_offset,
  output logic              err_csum,
  output logic              err_format,
  output logic              done
);
  logic              is_hex;
  logic              is_mark;
  logic              is_eol;
  logic [NIB_W-1:0]  nib;
  logic              in_body;
  logic              byte_valid;
  logic [BYTE_W-1:0] byte_val;

  hexp_char_class u_class (
    .ch      (in_char),
    .is_hex  (is_hex),
    .nib     (nib),
    .is_mark (is_mark),
    .is_eol  (is_eol)
  );

  hexp_nibble_pair u_pair (
    .clk        (clk),
    .rst        (rst),
    .clear      (!in_body),
    .nib_valid  (in_valid && is_hex && in_body),
    .nib        (nib),
    .byte_valid (byte_valid),
    .byte_val   (byte_val)
  );

  hexp_record_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .is_hex     (is_hex),
    .is_mark    (is_mark),
    .is_eol     (is_eol),
    .byte_valid (byte_valid),
    .byte_val   (byte_val),
    .in_body    (in_body),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_offset (out_offset),
    .err_csum   (err_csum),
    .err_format (err_format),
    .done       (done)
  );
endmodule

// File: rtl/hexp_checker.sv
module hexp_checker (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic err_csum,
  input logic err_format,
  input logic done
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !err_csum && !err_format && !done)); // R1

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $countones({out_valid, err_csum, err_format}) <= 1); // R5

  AST_EVENT_NEEDS_BEAT: assert property (@(posedge clk) disable iff (rst)
    (out_valid || err_csum || err_format) |-> $past(in_valid)); // R10

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R8

  AST_SILENT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!out_valid && !err_csum && !err_format)); // R8

  AST_DONE_RISE_BEAT: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(in_valid)); // R8
endmodule

bind hex_record_parser hexp_checker u_hexp_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .err_csum   (err_csum),
  .err_format (err_format),
  .done       (done)
);

// File: tb/hex_record_parser_bench.sv
module hex_record_parser_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h00;
  logic        out_valid;
  logic [7:0]  out_byte;
  logic [15:0] out_offset;
  logic        err_csum;
  logic        err_format;
  logic        done;

  int n_cmp  = 0;
  int n_mism = 0;

  always #10 clk = ~clk;

  hex_record_parser u_hex_record_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .out_valid(out_valid), .out_byte(out_byte), .out_offset(out_offset),
    .err_csum(err_csum), .err_format(err_format), .done(done)
  );

  // ---------------- behavioural reference model ----------------
  int            m_mode = 0;          // 0 between records, 1 inside, 2 finished
  byte unsigned  m_rec[$];
  int            m_digits = 0;
  int            m_hi = 0;
  bit            e_valid, e_csum, e_fmt, e_done;
  int            e_byte, e_off;

  function automatic int hex_val(input int c);
    if (c >= 48 && c <= 57)  return c - 48;
    if (c >= 65 && c <= 70)  return c - 55;
    if (c >= 97 && c <= 102) return c - 87;
    return -1;
  endfunction

  always @(posedge clk) begin
    e_valid = 0; e_csum = 0; e_fmt = 0;
    if (rst) begin
      m_mode = 0; e_done = 0; m_rec.delete();
    end else if (in_valid && m_mode != 2) begin
      int c;
      c = int'(in_char);
      if (m_mode == 0) begin
        if (c == 58) begin
          m_mode = 1; m_rec.delete(); m_digits = 0;
        end else if (c != 13 && c != 10) begin
          e_fmt = 1;
        end
      end else if (hex_val(c) < 0) begin
        e_fmt = 1; m_mode = 0;
      end else begin
        m_digits++;
        if (m_digits % 2 == 1) begin
          m_hi = hex_val(c);
        end else begin
          int idx;
          m_rec.push_back(byte'(m_hi * 16 + hex_val(c)));
          idx = m_rec.size() - 1;
          if (idx >= 4 && idx < 4 + int'(m_rec[0]) && m_rec[3] == 0) begin
            e_valid = 1;
            e_byte  = int'(m_rec[idx]);
            e_off   = (int'(m_rec[1]) * 256 + int'(m_rec[2]) + idx - 4) % 65536;
          end
          if (m_rec.size() == int'(m_rec[0]) + 5) begin
            int s;
            s = 0;
            foreach (m_rec[k]) s += int'(m_rec[k]);
            m_mode = 0;
            if (s % 256 != 0) e_csum = 1;
            else if (m_rec[3] == 1) begin m_mode = 2; e_done = 1; end
          end
        end
      end
    end
  end

  // ---------------- per-cycle comparison and port monitors ----------------
  int cnt_data = 0, cnt_csum = 0, cnt_fmt = 0, last_off = -1;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_mism++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R3", int'(out_valid), int'(e_valid), "out_valid");
      if (e_valid && out_valid) begin
        check("R2", int'(out_byte), e_byte, "out_byte");
        check("R3", int'(out_offset), e_off, "out_offset");
      end
      check("R5", int'(err_csum), int'(e_csum), "err_csum");
      check("R7", int'(err_format), int'(e_fmt), "err_format");
      check("R8", int'(done), int'(e_done), "done");
      if (out_valid) begin cnt_data++; last_off = int'(out_offset); end
      if (err_csum) cnt_csum++;
      if (err_format) cnt_fmt++;
    end
  end

  // ---------------- stimulus helpers ----------------
  byte unsigned pay[$];

  task automatic beat(input byte c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
  endtask

  task automatic idle_beat();
    @(negedge clk);
    in_valid = 1'b0;
    in_char  = 8'h3A;   // a start mark on an idle beat must be ignored (R10)
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) beat(s[i]);
  endtask

  function automatic byte hexc(input int n, input bit lower);
    if (n < 10) return byte'(48 + n);
    return byte'((lower ? 87 : 55) + n);
  endfunction

  task automatic send_byte(input int b, input bit lower, input bit gaps);
    beat(hexc((b >> 4) & 15, lower));
    if (gaps) idle_beat();
    beat(hexc(b & 15, lower));
    if (gaps) idle_beat();
  endtask

  task automatic send_rec(input int off, input int typ, input bit bad, input bit lower, input bit gaps);
    int s;
    s = pay.size() + (off >> 8) + (off & 255) + typ;
    foreach (pay[k]) s += int'(pay[k]);
    beat(8'h3A);
    send_byte(pay.size(), lower, gaps);
    send_byte((off >> 8) & 255, lower, gaps);
    send_byte(off & 255, lower, gaps);
    send_byte(typ, lower, gaps);
    foreach (pay[k]) send_byte(int'(pay[k]), lower, gaps);
    send_byte(((256 - (s % 256)) + (bad ? 1 : 0)) % 256, lower, gaps);
    beat(8'h0D);
    beat(8'h0A);
  endtask

  task automatic settle();
    idle_beat();
    idle_beat();
    idle_beat();
    #1;
  endtask

  task automatic clear_counts();
    cnt_data = 0; cnt_csum = 0; cnt_fmt = 0; last_off = -1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mism);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_mism++;
    $display("FAIL watchdog all actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs low after reset edges
    check("R1", int'({out_valid, err_csum, err_format, done}), 0, "flags in reset");
    @(negedge clk);
    rst = 1'b0;
    settle();

    // R5/R3: known-good record with checksum 0x77
    clear_counts();
    send_str(":0400000005FA394D77");
    beat(8'h0D); beat(8'h0A);
    settle();
    check("R3", cnt_data, 4, "data bytes of good record");
    check("R5", cnt_csum, 0, "csum errors on good record");
    check("R3", last_off, 3, "last offset");

    // R2/R10: lower-case digits with idle beats in between
    clear_counts();
    pay = '{8'hAB, 8'hcd, 8'h0f};
    send_rec(16'h1234, 0, 0, 1, 1);
    settle();
    check("R2", cnt_data, 3, "lower-case bytes");
    check("R10", cnt_fmt + cnt_csum, 0, "errors with idle beats");
    check("R3", last_off, 16'h1236, "offset with gaps");

    // R4: extension record and an unknown type give no data
    clear_counts();
    send_str(":020000040000FA\r\n");
    pay = '{8'h11, 8'h22};
    send_rec(16'h0040, 5, 0, 0, 0);
    settle();
    check("R4", cnt_data, 0, "data from non-data types");
    check("R4", cnt_csum + cnt_fmt, 0, "errors on non-data types");

    // R3: offset wraps past 0xFFFF
    clear_counts();
    pay = '{8'h01, 8'h02, 8'h03, 8'h04};
    send_rec(16'hFFFE, 0, 0, 0, 0);
    settle();
    check("R3", last_off, 1, "wrapped offset");
    check("R3", cnt_data, 4, "wrapped byte count");

    // R5: corrupted checksum
    clear_counts();
    pay = '{8'h55, 8'hAA};
    send_rec(16'h0004, 0, 1, 0, 0);
    settle();
    check("R5", cnt_csum, 1, "bad checksum flagged");

    // R11: zero-length data record
    clear_counts();
    pay.delete();
    send_rec(16'h0100, 0, 0, 0, 0);
    settle();
    check("R11", cnt_data + cnt_csum + cnt_fmt, 0, "zero-length record events");

    // R7: illegal digit, truncation by CR, and ':' inside a record
    clear_counts();
    send_str(":04G");
    settle();
    check("R7", cnt_fmt, 1, "non-hex digit in record");
    clear_counts();
    send_str(":02\r\n");
    settle();
    check("R7", cnt_fmt, 1, "record cut by line end");
    clear_counts();
    send_str(":0:");
    settle();
    check("R7", cnt_fmt, 1, "start mark inside record");

    // R6: line ends are skipped, a stray character is not
    clear_counts();
    send_str("\r\n\r\n");
    settle();
    check("R6", cnt_fmt, 0, "line ends between records");
    send_str("x");
    settle();
    check("R6", cnt_fmt, 1, "stray character between records");

    // R9: end-of-file with bad checksum, then parsing continues
    clear_counts();
    send_str(":00000001FE\r\n");
    settle();
    check("R9", cnt_csum, 1, "bad EOF checksum");
    check("R9", int'(done), 0, "done after bad EOF");
    pay = '{8'h99};
    send_rec(16'h0200, 0, 0, 0, 0);
    settle();
    check("R9", cnt_data, 1, "record after bad EOF");

    // R8: good end-of-file, then everything is ignored
    clear_counts();
    send_str(":00000001ff\r\n");
    settle();
    check("R8", int'(done), 1, "done after good EOF");
    pay = '{8'h12, 8'h34};
    send_rec(16'h0000, 0, 0, 0, 0);
    send_str("zz");
    settle();
    check("R8", cnt_data + cnt_csum + cnt_fmt, 0, "events after done");
    check("R8", int'(done), 1, "done held");

    summary();
    $finish;
  end
endmodule